// File: doc/BRIEF.md
# Event Timestamp Capture Unit

This block keeps a free-running binary counter that advances once per clock. At the intended 100 MHz clock each step is 10 ns. It watches a set of asynchronous digital inputs and, on each edge that software has chosen, it stores the counter value in hardware. Together with the counter value it stores the channel number and whether the edge was rising or falling. These records go into a small queue. Because the value is latched by logic at the edge, it carries no software jitter. Pulse width, period and frequency are worked out by the host from the differences between records.

The host microcontroller talks to the block over an SPI slave port. The first byte of each transaction is a command. The host can pop the oldest record, take a snapshot of the live counter, read the status flags and queue level, or write clear bits and the per-channel configuration. A level-type interrupt output goes high when the counter wraps, so the host can count wraps and extend the time base in software. If a second wrap arrives before that interrupt has been cleared, a separate flag records the loss.

Top module: `evt_stamp_top`

## Requirements
- R1: The counter is CNT_W bits wide (default 32), resets to 0, advances by exactly one on every clock, and wraps from all-ones to 0. Two live snapshots taken G clocks apart differ by G modulo 2^CNT_W.
- R2: On a wrap, `rollover_irq` goes high on the next cycle. It stays high until the host writes a clear with data byte 1 bit 0 set.
- R3: A wrap while `rollover_irq` is already high sets the missed-wrap flag (status byte 0 bit 1). Only data byte 1 bit 1 of a write clears it, and that clear leaves `rollover_irq` unchanged.
- R4: An edge on channel i makes a record only when enable bit i is set and the rise-select bit i (for a rising edge) or fall-select bit i (for a falling edge) is set. The record's polarity bit is 1 for a rising edge and 0 for a falling edge. A disabled channel or an unselected edge makes no record.
- R5: The stored timestamp is the counter value in the cycle just after the clock edge that first sampled the new input level. The synchroniser delay is removed, so two edges D clocks apart give timestamps that differ by exactly D.
- R6: Edges on several channels in the same clock all get records with the same timestamp. These records enter the queue lowest channel first.
- R7: The queue holds 16 records and returns them oldest first. A record that arrives when the queue is full is dropped, and the overflow flag (status byte 0 bit 2) is set. The flag stays set until a write with data byte 1 bit 2 set.
- R8: SPI uses mode 0, MSB first, with a command byte and then response bytes on `spi_miso`. Command 0x01 returns 5 bytes and pops one record. Byte 0 is {valid, 3'b000, polarity, channel[2:0]} and bytes 1 to 4 are the timestamp, zero-extended and MSB first. On an empty queue, valid is 0 and nothing is popped. `spi_miso` is 0 while chip select is high.
- R9: Command 0x02 returns 4 bytes. They hold the counter (zero-extended) latched on the cycle the command byte's last bit was taken, so the bytes cannot tear.
- R10: Command 0x03 returns 2 bytes. Byte 0 holds the flags: bit 0 interrupt pending, bit 1 missed wrap, bit 2 overflow, bit 3 queue empty. Byte 1 holds the queue fill level.
- R11: Command 0x04 takes data bytes in this order: byte 1 clear bits, byte 2 enable mask, byte 3 rise-select mask, byte 4 fall-select mask. Clears act as soon as byte 1 is complete. The three masks change together, and only when byte 4 is complete; a transaction that ends earlier leaves them unchanged. After reset all masks are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock, intended 100 MHz (one count per 10 ns) |
| rst_n | input | 1 | Synchronous active-low reset |
| evt_in | input | NCH | Asynchronous event inputs, one per channel |
| spi_sclk | input | 1 | SPI serial clock from host |
| spi_cs_n | input | 1 | SPI chip select, active low |
| spi_mosi | input | 1 | SPI data from host |
| spi_miso | output | 1 | SPI data to host |
| rollover_irq | output | 1 | Counter wrap interrupt, held until cleared |

## Verification
The hardest cases to reach from the ports are the counter wrap cases: the interrupt and the missed-wrap flag. With a 32-bit counter a wrap takes billions of cycles. The bench therefore builds the block with a 12-bit counter, so a wrap comes every 4096 clocks. It waits for the interrupt to rise, clears it, and then waits past two more wraps without clearing to produce a missed wrap. Timestamp accuracy cannot be seen as an absolute value from outside. It is checked through differences: edges driven a known number of clocks apart, same-clock edges on two channels, and pairs of live snapshots whose start cycles the bench records.

// File: rtl/ets_pkg.sv
// Package: shared constants for the event timestamp unit.
// Assumes records carry a fixed 32-bit time field and a 3-bit channel index.
package ets_pkg;
    localparam int TS_W    = 32;
    localparam int CH_W    = 3;
    localparam int REC_W   = 1 + CH_W + TS_W;
    localparam int RESP_W  = 40;

    localparam logic [7:0] OP_POP  = 8'h01;
    localparam logic [7:0] OP_LIVE = 8'h02;
    localparam logic [7:0] OP_STAT = 8'h03;
    localparam logic [7:0] OP_WR   = 8'h04;
endpackage

// File: rtl/ets_event_front.sv
// Module: per-channel input synchroniser and qualified edge detector.
// Assumes inputs are fully asynchronous; SYNC_STAGES >= 2. The hit output
// rises SYNC_STAGES-1 cycles after the edge that first sampled a new level.
module ets_event_front #(
    parameter int NCH         = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic [NCH-1:0] evt_in,
    input  logic [NCH-1:0] chan_en,
    input  logic [NCH-1:0] rise_sel,
    input  logic [NCH-1:0] fall_sel,
    output logic [NCH-1:0] hit,
    output logic [NCH-1:0] hit_pol
);
    for (genvar g = 0; g < NCH; g++) begin : g_ch
        logic [SYNC_STAGES-1:0] sync_q;
        logic                   prev_q;
        logic                   lvl;

        // Shift the raw input through the synchroniser and keep the last level
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                sync_q <= '0;
                prev_q <= 1'b0;
            end else begin
                sync_q <= {sync_q[SYNC_STAGES-2:0], evt_in[g]};
                prev_q <= sync_q[SYNC_STAGES-1];
            end
        end

        // Qualify the detected edge with enable and edge selects
        always_comb begin
            lvl        = sync_q[SYNC_STAGES-1];
            hit[g]     = chan_en[g] & ((rise_sel[g] & lvl & ~prev_q) |
                                       (fall_sel[g] & ~lvl & prev_q));
            hit_pol[g] = lvl;
        end
    end
endmodule

// File: rtl/ets_capture_arb.sv
// Module: per-channel capture slots plus a fixed-priority drain into the queue.
// Each hit latches the timestamp into its own slot, so same-cycle edges keep an
// identical time; the lowest pending channel is pushed first. A hit on a slot
// that is still pending and not being drained overwrites it and reports a loss.
module ets_capture_arb #(
    parameter int NCH = 8
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic [NCH-1:0]              hit,
    input  logic [NCH-1:0]              hit_pol,
    input  logic [ets_pkg::TS_W-1:0]    ts_in,
    output logic                        push,
    output logic [ets_pkg::REC_W-1:0]   push_rec,
    output logic                        lost
);
    import ets_pkg::*;

    logic [NCH-1:0]  pend;
    logic [NCH-1:0]  slot_pol;
    logic [TS_W-1:0] slot_ts [NCH];
    logic [NCH-1:0]  gnt;
    logic [CH_W-1:0] gidx;

    // Pick the lowest-numbered pending slot
    always_comb begin
        gnt  = '0;
        gidx = '0;
        for (int i = NCH - 1; i >= 0; i--) begin
            if (pend[i]) gidx = CH_W'(i);
        end
        if (|pend) gnt[gidx] = 1'b1;
    end

    // Present the granted slot as the queue write
    always_comb begin
        push     = |pend;
        push_rec = {slot_pol[gidx], gidx, slot_ts[gidx]};
        lost     = |(hit & pend & ~gnt);
    end

    // Fill slots on hits, free them when drained
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend     <= '0;
            slot_pol <= '0;
            for (int i = 0; i < NCH; i++) slot_ts[i] <= '0;
        end else begin
            for (int i = 0; i < NCH; i++) begin
                if (hit[i]) begin
                    pend[i]     <= 1'b1;
                    slot_pol[i] <= hit_pol[i];
                    slot_ts[i]  <= ts_in;
                end else if (gnt[i]) begin
                    pend[i] <= 1'b0;
                end
            end
        end
    end

    // R6
    hit_to_push_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (|hit) |=> push);
endmodule

// File: rtl/ets_rec_fifo.sv
// Module: record queue with first-word fall-through read.
// Assumes DEPTH is a power of two. A push when full is refused unless a pop
// happens in the same cycle; a refused push is reported on drop.
module ets_rec_fifo #(
    parameter int DEPTH = 16,
    parameter int W     = 36
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        push,
    input  logic [W-1:0]                din,
    input  logic                        pop,
    output logic [W-1:0]                dout,
    output logic                        empty,
    output logic [$clog2(DEPTH+1)-1:0]  level,
    output logic                        drop
);
    localparam int AW = $clog2(DEPTH);
    localparam int LW = $clog2(DEPTH + 1);

    logic [W-1:0]  mem [DEPTH];
    logic [AW-1:0] wr_ptr, rd_ptr;
    logic          full, accept, take;

    // Derive occupancy conditions and the accepted operations
    always_comb begin
        empty  = (level == '0);
        full   = (level == LW'(DEPTH));
        take   = pop && !empty;
        accept = push && (!full || take);
        drop   = push && !accept;
        dout   = mem[rd_ptr];
    end

    // Store accepted records
    always_ff @(posedge clk) begin
        if (accept) mem[wr_ptr] <= din;
    end

    // Advance pointers and the fill level
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            level  <= '0;
        end else begin
            if (accept) wr_ptr <= wr_ptr + 1'b1;
            if (take)   rd_ptr <= rd_ptr + 1'b1;
            case ({accept, take})
                2'b10:   level <= level + 1'b1;
                2'b01:   level <= level - 1'b1;
                default: level <= level;
            endcase
        end
    end

    // R7
    level_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        level <= LW'(DEPTH));
    // R7
    full_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (full && push && !pop) |=> $stable(level));
    // R8
    pop_nonempty_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pop |-> !empty);
endmodule

// File: rtl/ets_spi_port.sv
// Module: SPI mode-0 slave sampled in the core clock domain.
// Assumes the serial clock is at most one eighth of the core clock. The first
// byte is a command; the response word is loaded once, one cycle after the
// command strobe, and shifted out MSB first on later falling edges.
module ets_spi_port #(
    parameter int RESP_W = 40
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sclk,
    input  logic              cs_n,
    input  logic              mosi,
    output logic              miso,
    output logic              cmd_stb,
    output logic [7:0]        cmd_byte,
    output logic              dat_stb,
    output logic [7:0]        dat_byte,
    output logic [2:0]        dat_idx,
    input  logic [RESP_W-1:0] resp
);
    logic [1:0]        sclk_q, cs_q, mosi_q;
    logic              sclk_d;
    logic              active, rise, fall;
    logic [6:0]        rx;
    logic [7:0]        new_byte;
    logic [5:0]        bitcnt;
    logic [RESP_W-1:0] txsh;

    // Bring the serial lines into the core domain
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sclk_q <= '0;
            cs_q   <= 2'b11;
            mosi_q <= '0;
            sclk_d <= 1'b0;
        end else begin
            sclk_q <= {sclk_q[0], sclk};
            cs_q   <= {cs_q[0], cs_n};
            mosi_q <= {mosi_q[0], mosi};
            sclk_d <= sclk_q[1];
        end
    end

    // Decode serial clock edges inside a selected transaction
    always_comb begin
        active   = ~cs_q[1];
        rise     = active & sclk_q[1] & ~sclk_d;
        fall     = active & ~sclk_q[1] & sclk_d;
        new_byte = {rx, mosi_q[1]};
        miso     = txsh[RESP_W-1];
    end

    // Collect bits, emit byte strobes, and shift the response
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rx       <= '0;
            bitcnt   <= '0;
            txsh     <= '0;
            cmd_stb  <= 1'b0;
            cmd_byte <= '0;
            dat_stb  <= 1'b0;
            dat_byte <= '0;
            dat_idx  <= '0;
        end else if (!active) begin
            bitcnt  <= '0;
            txsh    <= '0;
            cmd_stb <= 1'b0;
            dat_stb <= 1'b0;
        end else begin
            cmd_stb <= 1'b0;
            dat_stb <= 1'b0;
            if (rise) begin
                rx <= new_byte[6:0];
                if (bitcnt != 6'd63) bitcnt <= bitcnt + 1'b1;
                if (bitcnt == 6'd7) begin
                    cmd_stb  <= 1'b1;
                    cmd_byte <= new_byte;
                end else if (bitcnt[2:0] == 3'd7) begin
                    dat_stb  <= 1'b1;
                    dat_byte <= new_byte;
                    dat_idx  <= bitcnt[5:3];
                end
            end
            if (cmd_stb) begin
                txsh <= resp;
            end else if (fall && bitcnt > 6'd8) begin
                txsh <= {txsh[RESP_W-2:0], 1'b0};
            end
        end
    end

    // R8
    miso_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !active |=> !miso);
endmodule

// File: rtl/evt_stamp_top.sv
// Module: event timestamp capture unit top level.
// Holds the free-running counter, wrap interrupt, status flags and host
// configuration, and joins the input front end, slot arbiter, record queue
// and SPI port. Assumes CNT_W <= 32 and NCH <= 8.
module evt_stamp_top #(
    parameter int NCH         = 8,
    parameter int CNT_W       = 32,
    parameter int SYNC_STAGES = 2,
    parameter int FIFO_DEPTH  = 16
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic [NCH-1:0] evt_in,
    input  logic           spi_sclk,
    input  logic           spi_cs_n,
    input  logic           spi_mosi,
    output logic           spi_miso,
    output logic           rollover_irq
);
    import ets_pkg::*;

    localparam int LVL_W = $clog2(FIFO_DEPTH + 1);
    localparam logic [CNT_W-1:0] LAT = CNT_W'(SYNC_STAGES - 1);

    logic [CNT_W-1:0]  cnt;
    logic              wrap;
    logic              missed_q, ovf_q, pv_q;
    logic [NCH-1:0]    en_q, rs_q, fs_q, en_stg, rs_stg;
    logic [7:0]        cur_cmd;
    logic [NCH-1:0]    hit, hit_pol;
    logic [TS_W-1:0]   ts_cap;
    logic              arb_push, arb_lost;
    logic [REC_W-1:0]  arb_rec, q_rec;
    logic              q_pop, q_empty, q_drop;
    logic [LVL_W-1:0]  q_level;
    logic              cmd_stb, dat_stb;
    logic [7:0]        cmd_byte, dat_byte;
    logic [2:0]        dat_idx;
    logic [RESP_W-1:0] resp;
    logic [2:0]        clr;

    // Free-running counter and wrap detect
    always_ff @(posedge clk) begin
        if (!rst_n) cnt <= '0;
        else        cnt <= cnt + 1'b1;
    end
    assign wrap = &cnt;

    // Marks cycles whose previous cycle was out of reset
    always_ff @(posedge clk) begin
        pv_q <= rst_n;
    end

    // Timestamp with synchroniser delay removed
    assign ts_cap = TS_W'(cnt - LAT);

    // Wrap interrupt, missed-wrap and overflow flags
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rollover_irq <= 1'b0;
            missed_q     <= 1'b0;
            ovf_q        <= 1'b0;
        end else begin
            if (wrap)        rollover_irq <= 1'b1;
            else if (clr[0]) rollover_irq <= 1'b0;
            if (wrap && rollover_irq) missed_q <= 1'b1;
            else if (clr[1])          missed_q <= 1'b0;
            if (arb_lost || q_drop) ovf_q <= 1'b1;
            else if (clr[2])        ovf_q <= 1'b0;
        end
    end

    // Command tracking and staged configuration writes
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cur_cmd <= '0;
            en_q    <= '0;
            rs_q    <= '0;
            fs_q    <= '0;
            en_stg  <= '0;
            rs_stg  <= '0;
        end else begin
            if (cmd_stb) cur_cmd <= cmd_byte;
            if (dat_stb && cur_cmd == OP_WR) begin
                case (dat_idx)
                    3'd2: en_stg <= dat_byte[NCH-1:0];
                    3'd3: rs_stg <= dat_byte[NCH-1:0];
                    3'd4: begin
                        en_q <= en_stg;
                        rs_q <= rs_stg;
                        fs_q <= dat_byte[NCH-1:0];
                    end
                    default: ;
                endcase
            end
        end
    end

    // Clear pulses from the first data byte of a write
    always_comb begin
        clr = (dat_stb && cur_cmd == OP_WR && dat_idx == 3'd1) ? dat_byte[2:0] : 3'b000;
    end

    // Response word for the command just received, and the pop request
    always_comb begin
        case (cmd_byte)
            OP_POP:  resp = {~q_empty, 3'b000, q_rec[REC_W-1], q_rec[REC_W-2 -: CH_W],
                             q_rec[TS_W-1:0]};
            OP_LIVE: resp = {TS_W'(cnt), 8'h00};
            OP_STAT: resp = {4'b0000, q_empty, ovf_q, missed_q, rollover_irq,
                             8'(q_level), 24'h000000};
            default: resp = '0;
        endcase
        q_pop = cmd_stb && cmd_byte == OP_POP && !q_empty;
    end

    ets_event_front #(.NCH(NCH), .SYNC_STAGES(SYNC_STAGES)) front_i (
        .clk(clk), .rst_n(rst_n), .evt_in(evt_in), .chan_en(en_q),
        .rise_sel(rs_q), .fall_sel(fs_q), .hit(hit), .hit_pol(hit_pol));

    ets_capture_arb #(.NCH(NCH)) arb_i (
        .clk(clk), .rst_n(rst_n), .hit(hit), .hit_pol(hit_pol), .ts_in(ts_cap),
        .push(arb_push), .push_rec(arb_rec), .lost(arb_lost));

    ets_rec_fifo #(.DEPTH(FIFO_DEPTH), .W(REC_W)) fifo_i (
        .clk(clk), .rst_n(rst_n), .push(arb_push), .din(arb_rec), .pop(q_pop),
        .dout(q_rec), .empty(q_empty), .level(q_level), .drop(q_drop));

    ets_spi_port #(.RESP_W(RESP_W)) spi_i (
        .clk(clk), .rst_n(rst_n), .sclk(spi_sclk), .cs_n(spi_cs_n), .mosi(spi_mosi),
        .miso(spi_miso), .cmd_stb(cmd_stb), .cmd_byte(cmd_byte), .dat_stb(dat_stb),
        .dat_byte(dat_byte), .dat_idx(dat_idx), .resp(resp));

    // R1
    cnt_step_chk: assert property (@(posedge clk) disable iff (!rst_n || !pv_q)
        cnt == CNT_W'($past(cnt) + 1'b1));
    // R2
    wrap_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wrap |=> rollover_irq);
    // R2
    irq_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rollover_irq && !clr[0]) |=> rollover_irq);
    // R3
    missed_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wrap && rollover_irq) |=> missed_q);
    // R7
    ovf_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (arb_lost || q_drop) |=> ovf_q);
endmodule

// File: tb/evt_stamp_top_tb_top.sv
// Directed bench for the event timestamp unit, built with a 12-bit counter.
module evt_stamp_top_tb_top;
    localparam int CW = 12;
    localparam logic [31:0] CMASK = (32'd1 << CW) - 1;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] evt = '0;
    logic       sclk = 1'b0, cs_n = 1'b1, mosi = 1'b0;
    logic       miso, irq;
    int         nchk = 0, nfail = 0, cyc = 0;

    always #2 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    evt_stamp_top #(.NCH(8), .CNT_W(CW), .SYNC_STAGES(2), .FIFO_DEPTH(16)) dut_i (
        .clk(clk), .rst_n(rst_n), .evt_in(evt), .spi_sclk(sclk), .spi_cs_n(cs_n),
        .spi_mosi(mosi), .spi_miso(miso), .rollover_irq(irq));

    task automatic chk(input string req, input logic [39:0] act, input logic [39:0] exp);
        nchk++;
        if (act !== exp) begin
            nfail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic spi_xfer(input logic [7:0] cmd, input logic [31:0] wdat, input int nb,
                            output logic [39:0] rdat, output int t0);
        logic [39:0] txv;
        txv  = {cmd, wdat};
        rdat = '0;
        t0   = cyc;
        @(negedge clk) cs_n = 1'b0;
        repeat (6) @(negedge clk);
        for (int i = 0; i < 8 * (nb + 1); i++) begin
            mosi = txv[39 - i];
            repeat (10) @(negedge clk);
            if (i >= 8) rdat[39 - (i - 8)] = miso;
            sclk = 1'b1;
            repeat (10) @(negedge clk);
            sclk = 1'b0;
        end
        repeat (6) @(negedge clk);
        cs_n = 1'b1;
        mosi = 1'b0;
        repeat (10) @(negedge clk);
    endtask

    task automatic pop_rec(output logic v, output logic p, output logic [2:0] ch,
                           output logic [31:0] ts);
        logic [39:0] r;
        int t;
        spi_xfer(8'h01, 32'h0, 5, r, t);
        v = r[39]; p = r[35]; ch = r[34:32]; ts = r[31:0];
    endtask

    task automatic get_stat(output logic [7:0] fl, output logic [7:0] lvl);
        logic [39:0] r;
        int t;
        spi_xfer(8'h03, 32'h0, 2, r, t);
        fl = r[39:32]; lvl = r[31:24];
    endtask

    task automatic write_cfg(input logic [2:0] c, input logic [7:0] en,
                             input logic [7:0] rs, input logic [7:0] fs);
        logic [39:0] r;
        int t;
        spi_xfer(8'h04, {5'b0, c, en, rs, fs}, 4, r, t);
    endtask

    task automatic write_clr(input logic [2:0] c);
        logic [39:0] r;
        int t;
        spi_xfer(8'h04, {5'b0, c, 24'h0}, 1, r, t);
    endtask

    task automatic quiesce();
        logic v, p; logic [2:0] ch; logic [31:0] ts;
        write_cfg(3'b000, 8'h00, 8'h00, 8'h00);
        evt = '0;
        repeat (10) @(negedge clk);
        for (int k = 0; k < 20; k++) begin
            pop_rec(v, p, ch, ts);
            if (!v) break;
        end
        write_clr(3'b100);
    endtask

    task automatic t_reset();
        logic [7:0] fl, lvl;
        logic v, p; logic [2:0] ch; logic [31:0] ts;
        chk("R2 irq after reset", 40'(irq), 40'd0);
        chk("R8 miso idle", 40'(miso), 40'd0);
        get_stat(fl, lvl);
        chk("R10 status flags after reset", 40'(fl), 40'h08);
        chk("R10 level after reset", 40'(lvl), 40'd0);
        pop_rec(v, p, ch, ts);
        chk("R8 pop on empty valid", 40'(v), 40'd0);
    endtask

    task automatic t_pulse();
        logic v, p; logic [2:0] ch; logic [31:0] a, b;
        quiesce();
        write_cfg(3'b000, 8'h02, 8'h02, 8'h02);
        @(negedge clk) evt[1] = 1'b1;
        repeat (50) @(negedge clk);
        evt[1] = 1'b0;
        repeat (20) @(negedge clk);
        pop_rec(v, p, ch, a);
        chk("R4 rise record valid/pol/ch", {37'(v), p, ch}, {37'd1, 1'b1, 3'd1});
        pop_rec(v, p, ch, b);
        chk("R4 fall record valid/pol/ch", {37'(v), p, ch}, {37'd1, 1'b0, 3'd1});
        chk("R5 pulse width 50", 40'((b - a) & CMASK), 40'd50);
    endtask

    task automatic t_select();
        logic v, p; logic [2:0] ch; logic [31:0] ts;
        logic [7:0] fl, lvl;
        quiesce();
        write_cfg(3'b000, 8'h08, 8'h00, 8'h08);
        @(negedge clk) begin evt[3] = 1'b1; evt[4] = 1'b1; end
        repeat (30) @(negedge clk);
        evt[3] = 1'b0; evt[4] = 1'b0;
        repeat (20) @(negedge clk);
        get_stat(fl, lvl);
        chk("R4 only selected edge recorded, level", 40'(lvl), 40'd1);
        pop_rec(v, p, ch, ts);
        chk("R4 falling-only record", {37'(v), p, ch}, {37'd1, 1'b0, 3'd3});
        pop_rec(v, p, ch, ts);
        chk("R4 disabled channel no record", 40'(v), 40'd0);
    endtask

    task automatic t_simul();
        logic v, p; logic [2:0] ch; logic [31:0] a, b;
        quiesce();
        write_cfg(3'b000, 8'h24, 8'h24, 8'h00);
        @(negedge clk) begin evt[5] = 1'b1; evt[2] = 1'b1; end
        repeat (20) @(negedge clk);
        pop_rec(v, p, ch, a);
        chk("R6 first record is channel 2", {38'(v), 2'b0} | 40'(ch), {38'd1, 2'b0} | 40'd2);
        pop_rec(v, p, ch, b);
        chk("R6 second record is channel 5", {38'(v), 2'b0} | 40'(ch), {38'd1, 2'b0} | 40'd5);
        chk("R6 same timestamp", 40'(b), 40'(a));
    endtask

    task automatic t_gap();
        logic v, p; logic [2:0] ch; logic [31:0] a, b;
        quiesce();
        write_cfg(3'b000, 8'h03, 8'h03, 8'h00);
        @(negedge clk) evt[0] = 1'b1;
        repeat (37) @(negedge clk);
        evt[1] = 1'b1;
        repeat (20) @(negedge clk);
        pop_rec(v, p, ch, a);
        pop_rec(v, p, ch, b);
        chk("R5 edge spacing 37", 40'((b - a) & CMASK), 40'd37);
    endtask

    task automatic t_live();
        logic [39:0] r1, r2;
        int t1, t2;
        spi_xfer(8'h02, 32'h0, 4, r1, t1);
        repeat (123) @(negedge clk);
        spi_xfer(8'h02, 32'h0, 4, r2, t2);
        // R1 and R9: snapshot difference equals elapsed clocks modulo 2^CW
        chk("R9 live count spacing", 40'((r2[39:8] - r1[39:8]) & CMASK),
            40'(32'(t2 - t1) & CMASK));
        chk("R1 live count within counter width", 40'(r2[39:8] & ~CMASK), 40'd0);
    endtask

    task automatic t_overflow();
        logic v, p; logic [2:0] ch; logic [31:0] ts;
        logic [7:0] fl, lvl;
        quiesce();
        write_cfg(3'b000, 8'h01, 8'h01, 8'h01);
        for (int k = 0; k < 17; k++) begin
            @(negedge clk) evt[0] = ~evt[0];
            repeat (12) @(negedge clk);
        end
        get_stat(fl, lvl);
        chk("R7 level full", 40'(lvl), 40'd16);
        chk("R7 overflow flag set", 40'(fl[2]), 40'd1);
        pop_rec(v, p, ch, ts);
        chk("R7 oldest first (rise)", {38'(v), 2'b0} | 40'(p), {38'd1, 2'b0} | 40'd1);
        pop_rec(v, p, ch, ts);
        chk("R7 second record (fall)", {38'(v), 2'b0} | 40'(p), {38'd1, 2'b0});
        write_clr(3'b100);
        get_stat(fl, lvl);
        chk("R7 overflow cleared", 40'(fl[2]), 40'd0);
        chk("R10 level after two pops", 40'(lvl), 40'd14);
    endtask

    task automatic t_partial();
        logic [39:0] r;
        int t;
        logic [7:0] fl, lvl;
        quiesce();
        spi_xfer(8'h04, {8'h00, 8'hFF, 16'h0}, 2, r, t);
        spi_xfer(8'h04, {8'h00, 8'hFF, 8'hFF, 8'h00}, 3, r, t);
        @(negedge clk) evt[6] = 1'b1;
        repeat (20) @(negedge clk);
        get_stat(fl, lvl);
        chk("R11 truncated write leaves masks unchanged", 40'(lvl), 40'd0);
        chk("R11 queue still empty flag", 40'(fl[3]), 40'd1);
    endtask

    task automatic t_roll();
        logic [7:0] fl, lvl;
        for (int k = 0; k < 5000 && !irq; k++) @(negedge clk);
        chk("R2 irq rises on wrap", 40'(irq), 40'd1);
        repeat (100) @(negedge clk);
        chk("R2 irq held", 40'(irq), 40'd1);
        write_clr(3'b111);
        chk("R2 irq cleared", 40'(irq), 40'd0);
        get_stat(fl, lvl);
        chk("R3 missed flag clear", 40'(fl[1:0]), 40'd0);
        repeat (2 * 4096 + 100) @(negedge clk);
        get_stat(fl, lvl);
        chk("R3 missed wrap flagged with irq", 40'(fl[1:0]), 40'd3);
        write_clr(3'b010);
        get_stat(fl, lvl);
        chk("R3 missed cleared alone", 40'(fl[1:0]), 40'd1);
        chk("R2 irq survives missed clear", 40'(irq), 40'd1);
        write_clr(3'b001);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        nchk++;
        nfail++;
        $display("FAIL watchdog expired");
        $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
        $finish;
    end

    initial begin
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        repeat (5) @(negedge clk);
        t_reset();
        t_pulse();
        t_select();
        t_simul();
        t_gap();
        t_live();
        t_overflow();
        t_partial();
        t_roll();
        $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
        $finish;
    end
endmodule